// File: doc/BRIEF.md
# Read-Address Lock Sequence Guard

This block guards erase and program operations on a parallel memory. It never looks at data. It watches only the read strobe and the read address, and it tracks progress through one of two fixed runs of seven read addresses. Completing one run puts the memory into the protected state. Completing the other run puts it into the unprotected state.

The registered protect flag feeds the command decoder, which must refuse erase and program while the flag is high. Software therefore unprotects the memory, does its erase or program work, and then protects the memory again.

Both runs share the same six opening addresses and differ only in the seventh. A one-cycle pulse marks every completed lock or unlock event.

Top module: `sdp_seq_guard`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `protected_o` is 1 (parameter `RESET_LOCKED` = 1) and both pulse outputs are 0.
- R2: The lock run is seven reads at key offsets 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419 and finally 0x040A. Completing it sets `protected_o` to 1 and raises `lock_pulse_o`.
- R3: The unlock run uses the same first six offsets with 0x041A as the seventh. Completing it clears `protected_o` to 0 and raises `unlock_pulse_o`.
- R4: A read is sampled on a rising edge. When the sampled read completes a run, the new flag value and the pulse are visible right after that same edge. The pulse lasts exactly one cycle and repeats even when the flag value does not change.
- R5: Only the low `CMP_W` (default 13) bits of `addr_i` are compared. Higher address bits have no effect.
- R6: A read that does not match the next expected offset discards all progress. If that read equals the first offset (0x1823), it counts as step one of a new run.
- R7: Cycles with `rd_en_i` low, whatever the address, neither advance nor clear progress.
- R8: A seventh read that matches neither final offset aborts the run with no flag change and no pulse. A lone final offset without the prefix does nothing either.
- R9: `protected_o` changes only together with a pulse, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_en_i | input | 1 | Read strobe; high for one cycle per read access |
| addr_i | input | ADDR_W (19) | Read address; low CMP_W bits are compared |
| protected_o | output | 1 | 1 = erase and program must be blocked |
| lock_pulse_o | output | 1 | One-cycle pulse when a lock run completes |
| unlock_pulse_o | output | 1 | One-cycle pulse when an unlock run completes |

## Verification
Every result of this block is due in the cycle right after the rising edge that samples the read: one register stage lies between a read and the flag and pulse outputs. The driver applies each read on a falling edge and, at the same time, queues the outputs a requirement-derived model predicts for the following rising edge. The monitor pops one entry per cycle and compares it 1 ns after that edge. Because idle cycles are queued as well, a pulse that arrives early, late, or lasts two cycles shows up as a mismatch in its own cycle.

// File: rtl/sdp_guard_pkg.sv
package sdp_guard_pkg;

   localparam int PREFIX_LEN = 6;
   localparam int KEY_W      = 13;

   localparam logic [KEY_W-1:0] LOCK_TAIL = 13'h040A;
   localparam logic [KEY_W-1:0] OPEN_TAIL = 13'h041A;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_LOCK = 2'd1,
      EV_OPEN = 2'd2
   } guard_ev_e;

   // Shared opening offsets, in the order they must be read.
   function automatic logic [KEY_W-1:0] prefix_key(input int idx);
      case (idx)
         0:       return 13'h1823;
         1:       return 13'h1820;
         2:       return 13'h1822;
         3:       return 13'h0418;
         4:       return 13'h041B;
         default: return 13'h0419;
      endcase
   endfunction

endpackage

// File: rtl/sdp_key_match.sv
module sdp_key_match
   import sdp_guard_pkg::*;
#(
   parameter int CMP_W = 13
) (
   input  logic [CMP_W-1:0]      key_i,
   output logic [PREFIX_LEN-1:0] step_hit_o,
   output logic                  lock_tail_o,
   output logic                  open_tail_o
);

   // One comparator per opening step.
   for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_step
      assign step_hit_o[g] = (key_i == CMP_W'(prefix_key(g)));
   end

   assign lock_tail_o = (key_i == CMP_W'(LOCK_TAIL));
   assign open_tail_o = (key_i == CMP_W'(OPEN_TAIL));

endmodule

// File: rtl/sdp_step_track.sv
module sdp_step_track
   import sdp_guard_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rd_en_i,
   input  logic [PREFIX_LEN-1:0] step_hit_i,
   input  logic                  lock_tail_i,
   input  logic                  open_tail_i,
   output guard_ev_e             ev_o
);

   localparam int CNT_W = $clog2(PREFIX_LEN + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(PREFIX_LEN);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             restart;

   // A breaking read that equals the first offset starts a new run.
   assign restart = step_hit_i[0];

   always_comb begin
      cnt_d = cnt_q;
      ev_o  = EV_NONE;
      if (rd_en_i) begin
         if (cnt_q == FULL) begin
            if (lock_tail_i) begin
               ev_o  = EV_LOCK;
               cnt_d = '0;
            end else if (open_tail_i) begin
               ev_o  = EV_OPEN;
               cnt_d = '0;
            end else begin
               cnt_d = restart ? CNT_W'(1) : '0;
            end
         end else if (step_hit_i[cnt_q]) begin
            cnt_d = cnt_q + CNT_W'(1);
         end else begin
            cnt_d = restart ? CNT_W'(1) : '0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

endmodule

// File: rtl/sdp_prot_state.sv
module sdp_prot_state
   import sdp_guard_pkg::*;
#(
   parameter bit RESET_LOCKED = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  guard_ev_e ev_i,
   output logic      prot_o,
   output logic      lock_pls_o,
   output logic      open_pls_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prot_o     <= RESET_LOCKED;
         lock_pls_o <= 1'b0;
         open_pls_o <= 1'b0;
      end else begin
         lock_pls_o <= (ev_i == EV_LOCK);
         open_pls_o <= (ev_i == EV_OPEN);
         if (ev_i == EV_LOCK)      prot_o <= 1'b1;
         else if (ev_i == EV_OPEN) prot_o <= 1'b0;
      end
   end

endmodule

// File: rtl/sdp_seq_guard.sv
module sdp_seq_guard
   import sdp_guard_pkg::*;
#(
   parameter int ADDR_W       = 19,
   parameter int CMP_W        = 13,
   parameter bit RESET_LOCKED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              protected_o,
   output logic              lock_pulse_o,
   output logic              unlock_pulse_o
);

   // Elaboration-time parameter checks.
   if (CMP_W < KEY_W) begin : g_bad_cmp
      $error("CMP_W must hold the 13-bit key offsets");
   end
   if (ADDR_W < CMP_W) begin : g_bad_addr
      $error("ADDR_W must not be narrower than CMP_W");
   end

   logic [CMP_W-1:0]      key;
   logic [PREFIX_LEN-1:0] step_hit;
   logic                  lock_tail, open_tail;
   guard_ev_e             ev;

   assign key = addr_i[CMP_W-1:0];

   // Upper bits take no part in matching.
   if (ADDR_W > CMP_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:CMP_W];
   end

   sdp_key_match #(.CMP_W(CMP_W)) i_match (
      .key_i       (key),
      .step_hit_o  (step_hit),
      .lock_tail_o (lock_tail),
      .open_tail_o (open_tail)
   );

   sdp_step_track i_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_en_i     (rd_en_i),
      .step_hit_i  (step_hit),
      .lock_tail_i (lock_tail),
      .open_tail_i (open_tail),
      .ev_o        (ev)
   );

   sdp_prot_state #(.RESET_LOCKED(RESET_LOCKED)) i_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (ev),
      .prot_o     (protected_o),
      .lock_pls_o (lock_pulse_o),
      .open_pls_o (unlock_pulse_o)
   );

endmodule

// File: rtl/sdp_seq_guard_chk.sv
module sdp_seq_guard_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic rd_en_i,
   input logic protected_o,
   input logic lock_pulse_o,
   input logic unlock_pulse_o
);

   // R9
   pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lock_pulse_o && unlock_pulse_o));

   // R9
   flag_needs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(protected_o) |-> (lock_pulse_o || unlock_pulse_o));

   // R2
   lock_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_pulse_o |-> protected_o);

   // R3
   open_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unlock_pulse_o |-> !protected_o);

   // R4
   lock_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_pulse_o |=> !lock_pulse_o);

   // R4
   open_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unlock_pulse_o |=> !unlock_pulse_o);

   // R7
   idle_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> !(lock_pulse_o || unlock_pulse_o));

endmodule

bind sdp_seq_guard sdp_seq_guard_chk i_sdp_seq_guard_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .rd_en_i        (rd_en_i),
   .protected_o    (protected_o),
   .lock_pulse_o   (lock_pulse_o),
   .unlock_pulse_o (unlock_pulse_o)
);

// File: tb/test_sdp_seq_guard.sv
module test_sdp_seq_guard;

   localparam int ADDR_W = 19;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              rd_en;
   logic [ADDR_W-1:0] addr;
   logic              prot, lpls, upls;

   always #2 clk = ~clk;   // 250 MHz

   sdp_seq_guard i_sdp_seq_guard (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .rd_en_i        (rd_en),
      .addr_i         (addr),
      .protected_o    (prot),
      .lock_pulse_o   (lpls),
      .unlock_pulse_o (upls)
   );

   typedef struct {
      logic  prot;
      logic  lk;
      logic  ul;
      string req;
   } exp_t;

   exp_t  sbq[$];
   int    n_cmp  = 0;
   int    n_bad  = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // Requirement model
   int m_prog = 0;
   bit m_prot = 1;

   function automatic logic [12:0] want(input int i);
      logic [12:0] t[6] = '{13'h1823, 13'h1820, 13'h1822,
                            13'h0418, 13'h041B, 13'h0419};
      return t[i];
   endfunction

   task automatic cyc(input bit rd, input logic [ADDR_W-1:0] a);
      exp_t e;
      logic [12:0] k;
      @(negedge clk);
      rd_en = rd;
      addr  = a;
      k     = a[12:0];
      e.lk  = 0;
      e.ul  = 0;
      if (rd) begin
         if (m_prog == 6 && k == 13'h040A) begin
            m_prot = 1; e.lk = 1; m_prog = 0;
         end else if (m_prog == 6 && k == 13'h041A) begin
            m_prot = 0; e.ul = 1; m_prog = 0;
         end else if (m_prog < 6 && k == want(m_prog)) begin
            m_prog++;
         end else begin
            m_prog = (k == 13'h1823) ? 1 : 0;
         end
      end
      e.prot = m_prot;
      e.req  = cur_req;
      sbq.push_back(e);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a);
      cyc(1'b1, a);
   endtask

   task automatic idle(input logic [ADDR_W-1:0] a);
      cyc(1'b0, a);
   endtask

   task automatic prefix(input logic [ADDR_W-1:0] hi);
      for (int i = 0; i < 6; i++) rd(hi | ADDR_W'(want(i)));
   endtask

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual prot/lock/unlock=%b expected %b", req, act, exp);
      end
   endtask

   // Monitor: one scoreboard entry per rising edge, compared 1 ns later.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.req, {prot, lpls, upls}, {e.prot, e.lk, e.ul});
         end
      end
   end

   // Watchdog
   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      rd_en = 0;
      addr  = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {prot, lpls, upls}, 3'b100);   // R1 during reset
      @(negedge clk);
      rst_n = 1;
      cur_req = "R1";
      idle('0);

      // R3 / R4: plain unlock run
      cur_req = "R3";
      prefix('0); rd(19'h0041A); idle('0); idle('0);

      // R2 / R4: plain lock run
      cur_req = "R2";
      prefix('0); rd(19'h0040A); idle('0);

      // R4: repeated lock while protected still pulses
      cur_req = "R4";
      prefix('0); rd(19'h0040A); idle('0);

      // R5: upper address bits set on every read
      cur_req = "R5";
      prefix(19'h7E000); rd(19'h5E41A); idle('0);
      prefix(19'h22000); rd(19'h3A40A); idle('0);

      // R6: broken run, then restart on the first offset
      cur_req = "R6";
      rd(19'h01823); rd(19'h01820); rd(19'h01823);
      rd(19'h01820); rd(19'h01822); rd(19'h00418);
      rd(19'h0041B); rd(19'h00419); rd(19'h0041A); idle('0);
      rd(19'h01823); rd(19'h01820); rd(19'h00000);
      rd(19'h01822); rd(19'h00418); rd(19'h0041B);
      rd(19'h00419); rd(19'h0040A); idle('0);

      // R7: idle cycles with address noise inside a run
      cur_req = "R7";
      rd(19'h01823); idle(19'h00000); rd(19'h01820); idle(19'h01234);
      rd(19'h01822); idle(19'h0040A); rd(19'h00418); rd(19'h0041B);
      idle(19'h0041A); rd(19'h00419); idle(19'h01823); rd(19'h0041A); idle('0);

      // R8: bad seventh read, lone tails
      cur_req = "R8";
      prefix('0); rd(19'h01234); idle('0);
      rd(19'h0040A); rd(19'h0041A); idle('0);
      prefix('0); rd(19'h01823); rd(19'h0040A); idle('0);

      // R9: restore protection, then a long quiet stretch
      cur_req = "R9";
      prefix('0); rd(19'h0040A);
      for (int i = 0; i < 10; i++) idle(ADDR_W'(i * 37));

      wait (sbq.size() == 0);
      @(posedge clk);
      #2;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule